// File: doc/BRIEF.md
# Seconds and Nanoseconds Time-of-Day Counter

This block keeps wall-clock time as two binary counts. One counts whole seconds from a starting point that software loads. The other counts the nanoseconds already elapsed in the current second. Every enabled reference tick adds a fixed number of nanoseconds to the fraction. When the fraction would reach one full second, it wraps back below one billion and carries one into the seconds count on the same clock edge. A 32-bit seconds count covers roughly 136 years before it wraps silently to zero.

Software never writes either count through the read path. A dedicated privileged load strobe writes both halves together, and counting resumes from the loaded values on the next tick. Reads go through a registered read port. Reading the seconds half also captures the fraction of that same cycle. A later read of the fraction half then returns the captured value, so the two words always describe one instant, however many ticks fall between the two reads. The present counts are also driven on two live outputs for observation.

Top module: `rtc_secfrac`

## Requirements
- R1: While reset is asserted and after it is released, the seconds output, the fraction output, read valid and read data are all zero.
- R2: A clock edge with the tick input high, load low and no wrap adds NS_PER_TICK to the fraction and leaves the seconds unchanged. An edge with both tick and load low changes neither count.
- R3: When the fraction plus NS_PER_TICK is NS_WRAP or more on a tick edge, the fraction becomes that sum minus NS_WRAP and the seconds count rises by one on the same edge.
- R4: The seconds count wraps from all ones to zero with no other visible effect.
- R5: An edge with load high sets the seconds to the seconds load value and the fraction to the fraction load value. This overrides a tick in the same cycle, and the next tick counts on from the loaded fraction.
- R6: A read with the select input at 0 (seconds half) returns, on the next cycle, the seconds value present during the read cycle, zero-extended to the read width. It also captures the fraction present in that same cycle.
- R7: A read with the select input at 1 (fraction half) returns, on the next cycle, the fraction captured by the latest seconds-half read, not the live fraction. It returns zero if no seconds-half read has happened since reset.
- R8: Read valid is high exactly on the cycle after a cycle with the read strobe high. Read data holds its last value when no read is made.
- R9: A fraction below NS_WRAP stays below NS_WRAP after any number of ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference tick enable: adds NS_PER_TICK on this edge |
| load_i | input | 1 | Privileged load strobe for both halves |
| load_sec_i | input | SEC_W | Seconds value to load |
| load_ns_i | input | NS_W | Fraction value to load, below NS_WRAP |
| rd_en_i | input | 1 | Read strobe |
| rd_sel_i | input | 1 | Read select: 0 seconds half, 1 fraction half |
| sec_o | output | SEC_W | Live seconds count |
| ns_o | output | NS_W | Live nanosecond fraction |
| rd_valid_o | output | 1 | Read data valid, one cycle after the strobe |
| rd_data_o | output | DATA_W | Read data, the wider of SEC_W and NS_W |

## Verification
The bench uses a small configuration: 4-bit seconds, a fraction that wraps at 100, and 7 per tick. Because 7 does not divide 100, the wrap residue changes from one second to the next. A run with a tick on every cycle passes through many full seconds and two complete seconds wraps. It separates a correct subtract-on-wrap from a reset-to-zero wrap, and it catches a missing or late carry. A sparse tick pattern shows that idle cycles hold both counts. A sweep loads every legal fraction value and then ticks once, which checks the exact boundary of the wrap compare. Read pairs separated by a varying number of ticks show that the fraction half returns the captured instant and not the live count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // Read-port half selector; the encoding matches the rd_sel_i pin.
    typedef enum logic {
        RD_SEC  = 1'b0,
        RD_FRAC = 1'b1
    } rtc_rd_sel_e;

endpackage

// File: rtl/rtc_frac_unit.sv
module rtc_frac_unit #(
    parameter int          NS_W        = 32,
    parameter int unsigned NS_PER_TICK = 10,
    parameter int unsigned NS_WRAP     = 1_000_000_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            load_i,
    input  logic [NS_W-1:0] load_ns_i,
    output logic [NS_W-1:0] ns_o,
    output logic            carry_o
);

    localparam logic [NS_W:0] INC_W  = (NS_W+1)'(NS_PER_TICK);
    localparam logic [NS_W:0] WRAP_W = (NS_W+1)'(NS_WRAP);

    typedef struct packed {
        logic [NS_W-1:0] ns;
    } frac_state_t;

    frac_state_t st_d, st_q;
    logic [NS_W:0]   sum_d;
    logic [NS_W-1:0] wrapped_d;
    logic            wrap_d;
    logic            carry_d;

    always_comb begin
        st_d      = st_q;
        carry_d   = 1'b0;
        sum_d     = {1'b0, st_q.ns} + INC_W;
        wrap_d    = (sum_d >= WRAP_W);
        wrapped_d = NS_W'(sum_d - WRAP_W);
        if (load_i) begin
            st_d.ns = load_ns_i;
        end else if (tick_i) begin
            carry_d = wrap_d;
            st_d.ns = wrap_d ? wrapped_d : sum_d[NS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ns_o    = st_q.ns;
    assign carry_o = carry_d;

endmodule

// File: rtl/rtc_sec_unit.sv
module rtc_sec_unit #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carry_i,
    input  logic             load_i,
    input  logic [SEC_W-1:0] load_sec_i,
    output logic [SEC_W-1:0] sec_o
);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
    } sec_state_t;

    sec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sec = load_sec_i;
        end else if (carry_i) begin
            // wraps silently at all ones
            st_d.sec = st_q.sec + SEC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o = st_q.sec;

endmodule

// File: rtl/rtc_read_snap.sv
module rtc_read_snap
    import rtc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int NS_W   = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  rtc_rd_sel_e       rd_sel_i,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [NS_W-1:0]   ns_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [NS_W-1:0]   snap;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_en_i;
        if (rd_en_i) begin
            unique case (rd_sel_i)
                RD_SEC: begin
                    st_d.data = DATA_W'(sec_i);
                    st_d.snap = ns_i;
                end
                RD_FRAC: begin
                    st_d.data = DATA_W'(st_q.snap);
                end
                default: begin
                    st_d.data = st_q.data;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid_o = st_q.valid;
    assign rd_data_o  = st_q.data;

endmodule

// File: rtl/rtc_secfrac.sv
module rtc_secfrac
    import rtc_pkg::*;
#(
    parameter int          SEC_W       = 32,
    parameter int          NS_W        = 32,
    parameter int unsigned NS_PER_TICK = 10,
    parameter int unsigned NS_WRAP     = 1_000_000_000,
    localparam int         DATA_W      = (SEC_W > NS_W) ? SEC_W : NS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [SEC_W-1:0]  load_sec_i,
    input  logic [NS_W-1:0]   load_ns_i,
    input  logic              rd_en_i,
    input  logic              rd_sel_i,
    output logic [SEC_W-1:0]  sec_o,
    output logic [NS_W-1:0]   ns_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);

    logic        carry;
    rtc_rd_sel_e rd_sel;

    assign rd_sel = rtc_rd_sel_e'(rd_sel_i);

    rtc_frac_unit #(
        .NS_W        (NS_W),
        .NS_PER_TICK (NS_PER_TICK),
        .NS_WRAP     (NS_WRAP)
    ) u_frac (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .load_i    (load_i),
        .load_ns_i (load_ns_i),
        .ns_o      (ns_o),
        .carry_o   (carry)
    );

    rtc_sec_unit #(
        .SEC_W (SEC_W)
    ) u_sec (
        .clk        (clk),
        .rst_n      (rst_n),
        .carry_i    (carry),
        .load_i     (load_i),
        .load_sec_i (load_sec_i),
        .sec_o      (sec_o)
    );

    rtc_read_snap #(
        .SEC_W  (SEC_W),
        .NS_W   (NS_W),
        .DATA_W (DATA_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en_i),
        .rd_sel_i   (rd_sel),
        .sec_i      (sec_o),
        .ns_i       (ns_o),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

endmodule

// File: rtl/rtc_secfrac_chk.sv
module rtc_secfrac_chk #(
    parameter int          SEC_W       = 32,
    parameter int          NS_W        = 32,
    parameter int unsigned NS_PER_TICK = 10,
    parameter int unsigned NS_WRAP     = 1_000_000_000,
    parameter int          DATA_W      = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              load_i,
    input logic [SEC_W-1:0]  load_sec_i,
    input logic [NS_W-1:0]   load_ns_i,
    input logic              rd_en_i,
    input logic              rd_sel_i,
    input logic [SEC_W-1:0]  sec_o,
    input logic [NS_W-1:0]   ns_o,
    input logic              rd_valid_o,
    input logic [DATA_W-1:0] rd_data_o
);

    localparam logic [NS_W:0] INC_W  = (NS_W+1)'(NS_PER_TICK);
    localparam logic [NS_W:0] WRAP_W = (NS_W+1)'(NS_WRAP);

    logic          past_ok;
    logic [NS_W:0] sum_w;
    logic          wrap_w;
    logic          in_range;

    assign sum_w    = {1'b0, ns_o} + INC_W;
    assign wrap_w   = (sum_w >= WRAP_W);
    assign in_range = ({1'b0, ns_o} < WRAP_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (sec_o == '0 && ns_o == '0 && !rd_valid_o && rd_data_o == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !tick_i && !load_i) |=> ($stable(sec_o) && $stable(ns_o))); // R2

    AST_FRAC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && tick_i && !load_i && !wrap_w) |=>
            (ns_o == $past(sum_w[NS_W-1:0]) && $stable(sec_o))); // R2

    AST_CARRY_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && tick_i && !load_i && wrap_w) |=>
            (sec_o == SEC_W'($past(sec_o) + SEC_W'(1)))); // R3

    AST_SEC_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && tick_i && !load_i && wrap_w && (&sec_o)) |=> (sec_o == '0)); // R4

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && load_i) |=>
            (sec_o == $past(load_sec_i) && ns_o == $past(load_ns_i))); // R5

    AST_RD_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rd_en_i && !rd_sel_i) |=> (rd_data_o == DATA_W'($past(sec_o)))); // R6

    AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |=> (rd_valid_o == $past(rd_en_i))); // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !rd_en_i) |=> $stable(rd_data_o)); // R8

    AST_FRAC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !load_i && in_range) |=> ({1'b0, ns_o} < WRAP_W)); // R9

endmodule

bind rtc_secfrac rtc_secfrac_chk #(
    .SEC_W       (SEC_W),
    .NS_W        (NS_W),
    .NS_PER_TICK (NS_PER_TICK),
    .NS_WRAP     (NS_WRAP),
    .DATA_W      (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .load_i     (load_i),
    .load_sec_i (load_sec_i),
    .load_ns_i  (load_ns_i),
    .rd_en_i    (rd_en_i),
    .rd_sel_i   (rd_sel_i),
    .sec_o      (sec_o),
    .ns_o       (ns_o),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
);

// File: tb/rtc_secfrac_tb.sv
module rtc_secfrac_tb;

    localparam int SW  = 4;
    localparam int NW  = 8;
    localparam int INC = 7;
    localparam int WR  = 100;
    localparam int DW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic          load_i = 1'b0;
    logic [SW-1:0] load_sec_i = '0;
    logic [NW-1:0] load_ns_i = '0;
    logic          rd_en_i = 1'b0;
    logic          rd_sel_i = 1'b0;
    logic [SW-1:0] sec_o;
    logic [NW-1:0] ns_o;
    logic          rd_valid_o;
    logic [DW-1:0] rd_data_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int m_sec = 0, m_ns = 0, m_snap = 0, m_data = 0, m_valid = 0;

    always #2 clk = ~clk;

    rtc_secfrac #(
        .SEC_W       (SW),
        .NS_W        (NW),
        .NS_PER_TICK (INC),
        .NS_WRAP     (WR)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (load_i),
        .load_sec_i (load_sec_i),
        .load_ns_i  (load_ns_i),
        .rd_en_i    (rd_en_i),
        .rd_sel_i   (rd_sel_i),
        .sec_o      (sec_o),
        .ns_o       (ns_o),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "sec_o",      int'(sec_o),      m_sec);
        check(tag, "ns_o",       int'(ns_o),       m_ns);
        check(tag, "rd_valid_o", int'(rd_valid_o), m_valid);
        check(tag, "rd_data_o",  int'(rd_data_o),  m_data);
    endtask

    // Called at a falling edge: drive, let one rising edge pass, update model.
    task automatic step(input bit tk, input bit ld, input int ls, input int lns,
                        input bit re, input bit rs);
        int ps, pn;
        tick_i     = tk;
        load_i     = ld;
        load_sec_i = SW'(ls);
        load_ns_i  = NW'(lns);
        rd_en_i    = re;
        rd_sel_i   = rs;
        @(posedge clk);
        ps = m_sec;
        pn = m_ns;
        m_valid = re ? 1 : 0;
        if (re) begin
            if (!rs) begin
                m_data = ps;
                m_snap = pn;
            end else begin
                m_data = m_snap;
            end
        end
        if (ld) begin
            m_sec = ls % (1 << SW);
            m_ns  = lns;
        end else if (tk) begin
            m_ns = m_ns + INC;
            if (m_ns >= WR) begin
                m_ns  = m_ns - WR;
                m_sec = (m_sec + 1) % (1 << SW);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // Dense ticking: many full seconds and two seconds wraps.
        for (int i = 0; i < 500; i++) begin
            step(1, 0, 0, 0, 0, 0);
            check_all("R3 R4 dense ticks");
        end

        // Sparse ticking: idle cycles must hold both counts.
        for (int i = 0; i < 300; i++) begin
            step((i % 3) == 0, 0, 0, 0, 0, 0);
            check_all("R2 sparse ticks");
        end

        // Load every legal fraction, then tick once across the wrap boundary.
        for (int v = 0; v < WR; v++) begin
            step(v[0], 1, v % 16, v, 0, 0);
            check_all("R5 load");
            step(1, 0, 0, 0, 0, 0);
            check_all("R9 tick after load");
        end

        // Seconds wrap right after a load of all ones.
        step(0, 1, 15, 95, 0, 0);
        check_all("R5 load max");
        step(1, 0, 0, 0, 0, 0);
        check_all("R4 seconds wrap");

        // Coherent read pairs separated by varying tick counts.
        for (int k = 0; k < 25; k++) begin
            step(1, 0, 0, 0, 1, 0);
            check_all("R6 read seconds half");
            for (int j = 0; j < (k % 6); j++) begin
                step(1, 0, 0, 0, 0, 0);
                check_all("R8 no read");
            end
            step(k[0], 0, 0, 0, 1, 1);
            check_all("R7 read fraction half");
        end

        // Read of the seconds half in a load cycle sees the old values.
        step(1, 1, 3, 40, 1, 0);
        check_all("R6 read during load");
        step(0, 0, 0, 0, 1, 1);
        check_all("R7 captured before load");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule